// File: doc/BRIEF.md
# Programmable Serial Frame Master

This block runs single serial transfers as a clock-and-frame master. On a start request it latches one configuration word and a parallel transmit word. It then generates the serial clock, a frame-sync pulse and the transmit data line, and it shifts receive data in from a separate line. A transfer is a sequence of four periods, each counted in serial clock periods. First comes a quiet lead-in, during which the clock does not run. Then come an optional pre-pad, the data bits sent most significant first, and an optional post-pad. The frame-sync pulse is placed independently of the data. Its start is given in half clock periods from the beginning of the transfer and its length in full periods, so it may begin partway through the data.

The serial clock runs off the system clock through a programmable divider that counts half periods. Four clock modes choose the idle level and whether the first half of each active period sits at the idle level. The frame-sync level can be active high or active low. After the last data bit the transmit line either rests low or keeps the last bit sent. A start request whose frame timing is inconsistent is refused with an error pulse and no transfer runs. Configuration changes and start requests made while a transfer is in progress have no effect.

Top module: `frame_serial_master`

## Requirements
- R1: Clock modes. The idle level of `sclk` is `cfg_clk_mode[1]`. In every active period, modes 0 and 2 hold the idle level in the first half and the opposite level in the second half, and modes 1 and 3 do the reverse. Receive sampling falls between the two halves.
- R2: `sclk` sits at its idle level throughout the lead-in periods and whenever no transfer is running.
- R3: With `cfg_frm_pol`=1, `frm` is high while the frame is asserted and low otherwise. With `cfg_frm_pol`=0 the levels are swapped. After reset `frm` is 1, `sclk` is 0 and `txd` is 0.
- R4: Half periods are numbered from 0 at the start of the transfer. `frm` is asserted on half periods `cfg_frm_dly` through `cfg_frm_dly + 2*cfg_frm_len - 1`.
- R5: The phases run in this order: lead-in of `cfg_lead` periods, pre-pad of `cfg_pre_pad` periods, `cfg_bits` data periods and post-pad of `cfg_post_pad` periods. During the data periods `txd` carries `tx_word[cfg_bits-1:0]`, most significant bit first. During the lead-in and pre-pad `txd` is 0.
- R6: From the post-pad onward, and until the next transfer starts, `txd` equals `tx_word[0]` when `cfg_hold_last`=1 and 0 otherwise.
- R7: In each data period `rx_line` is captured at the end of the first half. The received bits appear right-aligned and zero-extended on `rx_word`, with `done` high for exactly one cycle in the cycle after the last half period ends. `busy` drops in that same cycle.
- R8: A start is refused if any of these holds: `cfg_bits` is outside 4..32, `cfg_frm_dly` > 88, `cfg_frm_len` is outside 1..44, `cfg_frm_dly + 2*cfg_frm_len` > 2*(total periods), `cfg_frm_len` >= `cfg_pre_pad + cfg_bits + cfg_post_pad`, or `cfg_frm_dly + 2*cfg_frm_len` < 2*(`cfg_lead`+1). A refused start gives a one-cycle `err` pulse and `busy` stays 0.
- R9: While `busy` is 1, `start` and all configuration and data inputs are ignored, and no second transfer is queued.
- R10: Each half period lasts `cfg_half_div`+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transfer (sampled when idle) |
| cfg_clk_mode | input | 2 | Clock mode 0..3 |
| cfg_frm_pol | input | 1 | 1 = frame active high |
| cfg_lead | input | 3 | Lead-in periods, 0..7 |
| cfg_pre_pad | input | 2 | Pre-pad periods, 0..3 |
| cfg_bits | input | 6 | Data bits, 4..32 |
| cfg_post_pad | input | 2 | Post-pad periods, 0..3 |
| cfg_frm_dly | input | 7 | Frame start in half periods, 0..88 |
| cfg_frm_len | input | 6 | Frame length in periods, 1..44 |
| cfg_hold_last | input | 1 | 1 = keep last bit on txd after data |
| cfg_half_div | input | DIV_W | System clocks per half period minus one |
| tx_word | input | DATA_W | Transmit word, right-aligned |
| rx_line | input | 1 | Serial receive data |
| sclk | output | 1 | Serial clock |
| frm | output | 1 | Frame-sync |
| txd | output | 1 | Serial transmit data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle refused-start pulse |
| rx_word | output | DATA_W | Received word, right-aligned |

## Verification
The bench samples the middle of every half period, so a clock drawn in the wrong half for one mode, or one that runs during the lead-in, shows up as a per-half mismatch. It places a frame that starts in the middle of a 32-bit data phase and another that ends exactly on the last half period; a frame counter off by one half would cut the pulse short or let it run past the end. It probes each timing rule alone with an otherwise legal setting, so a design that skipped one rule would start a transfer instead of pulsing the error. It also fires a start with altered inputs mid-transfer, so a design that relatched its configuration would corrupt the waveform or run a second transfer.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int MODE_W   = 2;
  localparam int LEAD_W   = 3;
  localparam int PAD_W    = 2;
  localparam int BITS_W   = 6;
  localparam int FDLY_W   = 7;
  localparam int FLEN_W   = 6;
  localparam int HALF_W   = 8;
  localparam int BITS_MIN = 4;
  localparam int FDLY_MAX = 88;
  localparam int FLEN_MAX = 44;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              pol;
    logic [LEAD_W-1:0] lead;
    logic [PAD_W-1:0]  pre;
    logic [BITS_W-1:0] bits;
    logic [PAD_W-1:0]  post;
    logic [FDLY_W-1:0] fdly;
    logic [FLEN_W-1:0] flen;
    logic              hold;
  } sfm_cfg_t;

  // frame timing rules checked at start (R8)
  function automatic logic cfg_legal(input sfm_cfg_t c, input int max_bits);
    int tot, fend;
    tot  = int'(c.lead) + int'(c.pre) + int'(c.bits) + int'(c.post);
    fend = int'(c.fdly) + 2 * int'(c.flen);
    cfg_legal = (int'(c.bits) >= BITS_MIN) && (int'(c.bits) <= max_bits)
             && (int'(c.fdly) <= FDLY_MAX)
             && (int'(c.flen) >= 1) && (int'(c.flen) <= FLEN_MAX)
             && (fend <= 2 * tot)
             && (int'(c.flen) < int'(c.pre) + int'(c.bits) + int'(c.post))
             && (fend >= 2 * (int'(c.lead) + 1));
  endfunction

endpackage

// File: rtl/sfm_halfdiv.sv
module sfm_halfdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] lim,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R10: with a divider above zero two ticks are never adjacent
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && lim != '0) |=> !tick);

endmodule

// File: rtl/sfm_phase.sv
module sfm_phase
  import sfm_pkg::*;
(
  input  logic [HALF_W-1:0] hcnt,
  input  logic [LEAD_W-1:0] lead,
  input  logic [PAD_W-1:0]  pre,
  input  logic [BITS_W-1:0] bits,
  input  logic [PAD_W-1:0]  post,
  input  logic [FDLY_W-1:0] fdly,
  input  logic [FLEN_W-1:0] flen,
  output logic              in_lead,
  output logic              in_data,
  output logic              past_data,
  output logic              frame_on,
  output logic              last_half
);

  logic [HALF_W-1:0] per, dstart, dend, tot2, fbeg, fend;

  always_comb begin
    per       = {1'b0, hcnt[HALF_W-1:1]};
    dstart    = HALF_W'(lead) + HALF_W'(pre);
    dend      = dstart + HALF_W'(bits);
    tot2      = (dend + HALF_W'(post)) << 1;
    fbeg      = HALF_W'(fdly);
    fend      = fbeg + (HALF_W'(flen) << 1);
    in_lead   = per < HALF_W'(lead);
    in_data   = (per >= dstart) && (per < dend);
    past_data = per >= dend;
    frame_on  = (hcnt >= fbeg) && (hcnt < fend);
    last_half = hcnt == (tot2 - 1'b1);
  end

endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter #(
  parameter int DATA_W = 32,
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [BITS_W-1:0] bits,
  input  logic              shift,
  input  logic              capture,
  input  logic              rx_in,
  output logic              tx_msb,
  output logic              tx_lsb,
  output logic [DATA_W-1:0] rx_sr
);

  localparam int SH_W = BITS_W + 1;

  logic [DATA_W-1:0] tx_sr;
  logic [SH_W-1:0]   align;

  assign align  = SH_W'(DATA_W) - {1'b0, bits};
  assign tx_msb = tx_sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr  <= '0;
      tx_lsb <= 1'b0;
      rx_sr  <= '0;
    end else if (load) begin
      tx_sr  <= tx_word << align;   // MSB of the live bits to the top
      tx_lsb <= tx_word[0];
      rx_sr  <= '0;
    end else begin
      if (shift)   tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (capture) rx_sr <= {rx_sr[DATA_W-2:0], rx_in};
    end
  end

  // R7: a half period never both samples and advances the data
  a_r7_one_action: assert property (@(posedge clk) disable iff (rst)
    !(shift && capture));

endmodule

// File: rtl/frame_serial_master.sv
module frame_serial_master
  import sfm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        cfg_clk_mode,
  input  logic              cfg_frm_pol,
  input  logic [2:0]        cfg_lead,
  input  logic [1:0]        cfg_pre_pad,
  input  logic [5:0]        cfg_bits,
  input  logic [1:0]        cfg_post_pad,
  input  logic [6:0]        cfg_frm_dly,
  input  logic [5:0]        cfg_frm_len,
  input  logic              cfg_hold_last,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              rx_line,
  output logic              sclk,
  output logic              frm,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rx_word
);

  sfm_cfg_t          cfg_in, cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [HALF_W-1:0] hcnt;
  logic              legal, accept, reject, tick;
  logic              in_lead, in_data, past_data, frame_on, last_half;
  logic              shift, capture, tx_msb, tx_lsb, end_lvl;
  logic              sclk_n, frm_n, txd_n;
  logic [DATA_W-1:0] rx_sr;

  assign cfg_in = '{mode: cfg_clk_mode, pol: cfg_frm_pol, lead: cfg_lead,
                    pre: cfg_pre_pad, bits: cfg_bits, post: cfg_post_pad,
                    fdly: cfg_frm_dly, flen: cfg_frm_len, hold: cfg_hold_last};
  assign legal  = cfg_legal(cfg_in, DATA_W);
  assign accept = start && !busy && legal;
  assign reject = start && !busy && !legal;

  sfm_halfdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .lim(div_q), .tick(tick));

  sfm_phase u_phase (
    .hcnt(hcnt), .lead(cfg_q.lead), .pre(cfg_q.pre), .bits(cfg_q.bits),
    .post(cfg_q.post), .fdly(cfg_q.fdly), .flen(cfg_q.flen),
    .in_lead(in_lead), .in_data(in_data), .past_data(past_data),
    .frame_on(frame_on), .last_half(last_half));

  assign shift   = busy && tick &&  hcnt[0] && in_data;
  assign capture = busy && tick && !hcnt[0] && in_data;

  sfm_shifter #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .tx_word(tx_word), .bits(cfg_in.bits),
    .shift(shift), .capture(capture), .rx_in(rx_line),
    .tx_msb(tx_msb), .tx_lsb(tx_lsb), .rx_sr(rx_sr));

  // next output levels from the current half period
  always_comb begin
    end_lvl = cfg_q.hold & tx_lsb;
    if (busy && !in_lead) sclk_n = cfg_q.mode[1] ^ hcnt[0] ^ cfg_q.mode[0];
    else                  sclk_n = cfg_q.mode[1];
    frm_n = (busy && frame_on) ? cfg_q.pol : !cfg_q.pol;
    if (!busy)          txd_n = end_lvl;
    else if (in_data)   txd_n = tx_msb;
    else if (past_data) txd_n = end_lvl;
    else                txd_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      cfg_q   <= '0;
      div_q   <= '0;
      hcnt    <= '0;
      sclk    <= 1'b0;
      frm     <= 1'b1;
      txd     <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      err  <= reject;
      sclk <= sclk_n;
      frm  <= frm_n;
      txd  <= txd_n;
      if (accept) begin
        cfg_q <= cfg_in;
        div_q <= cfg_half_div;
        hcnt  <= '0;
        busy  <= 1'b1;
      end else if (tick) begin
        if (last_half) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_word <= rx_sr;
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7: the end of busy coincides with done
  a_r7_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R8: a refused start leaves the engine idle
  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done));
  // R2: clock idles through the lead-in
  a_r2_lead_idle: assert property (@(posedge clk) disable iff (rst)
    (busy && in_lead) |=> (sclk == cfg_q.mode[1]));
  // R5: data line low during the lead-in
  a_r5_lead_low: assert property (@(posedge clk) disable iff (rst)
    (busy && in_lead) |=> !txd);
  // R3: frame inactive between transfers
  a_r3_frame_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> (frm == !cfg_q.pol));
  // R9: a start while busy leaves the latched setup alone
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(cfg_q));

endmodule

// File: tb/sim_frame_serial_master.sv
`timescale 1ns/1ps
module sim_frame_serial_master;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_clk_mode = '0;
  logic        cfg_frm_pol = 1'b0;
  logic [2:0]  cfg_lead = '0;
  logic [1:0]  cfg_pre_pad = '0;
  logic [5:0]  cfg_bits = 6'd8;
  logic [1:0]  cfg_post_pad = '0;
  logic [6:0]  cfg_frm_dly = '0;
  logic [5:0]  cfg_frm_len = 6'd1;
  logic        cfg_hold_last = 1'b0;
  logic [7:0]  cfg_half_div = '0;
  logic [31:0] tx_word = '0;
  logic        rx_line = 1'b0;
  logic        sclk, frm, txd, busy, done, err;
  logic [31:0] rx_word;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  frame_serial_master u0 (
    .clk(clk), .rst(rst), .start(start), .cfg_clk_mode(cfg_clk_mode),
    .cfg_frm_pol(cfg_frm_pol), .cfg_lead(cfg_lead), .cfg_pre_pad(cfg_pre_pad),
    .cfg_bits(cfg_bits), .cfg_post_pad(cfg_post_pad), .cfg_frm_dly(cfg_frm_dly),
    .cfg_frm_len(cfg_frm_len), .cfg_hold_last(cfg_hold_last),
    .cfg_half_div(cfg_half_div), .tx_word(tx_word), .rx_line(rx_line),
    .sclk(sclk), .frm(frm), .txd(txd), .busy(busy), .done(done), .err(err),
    .rx_word(rx_word));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic pick(input logic [31:0] w, input int bits, input int ds, input int q);
    if (q >= ds && q < ds + bits) return w[bits-1-(q-ds)];
    return 1'b0;
  endfunction

  // full transfer with per-half-period waveform checks
  task automatic run_xfer(input int m, input int pol, input int lead, input int pre,
                          input int bits, input int post, input int fdly, input int flen,
                          input int hold, input int div, input logic [31:0] tx,
                          input logic [31:0] rx, input bit poke, input string name);
    int tot, ds, de, s_bad, l_bad, f_bad, t_bad, e_bad, b_bad;
    logic idle, es, ef, et;
    logic [31:0] mask;
    tot = lead + pre + bits + post;
    ds  = lead + pre;
    de  = ds + bits;
    s_bad = 0; l_bad = 0; f_bad = 0; t_bad = 0; e_bad = 0; b_bad = 0;
    idle = m[1];
    mask = (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
    cfg_clk_mode = m[1:0]; cfg_frm_pol = pol[0]; cfg_lead = lead[2:0];
    cfg_pre_pad = pre[1:0]; cfg_bits = bits[5:0]; cfg_post_pad = post[1:0];
    cfg_frm_dly = fdly[6:0]; cfg_frm_len = flen[5:0]; cfg_hold_last = hold[0];
    cfg_half_div = div[7:0]; tx_word = tx;
    rx_line = pick(rx, bits, ds, 0);
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int h = 0; h < 2 * tot; h++) begin
      repeat (div + 1) begin
        @(posedge clk); #1 start = 1'b0;
      end
      es = (h / 2 < lead) ? idle : (idle ^ h[0] ^ m[0]);
      ef = (h >= fdly && h < fdly + 2 * flen) ? pol[0] : !pol[0];
      if (h / 2 < ds)      et = 1'b0;
      else if (h / 2 < de) et = tx[bits-1-(h/2-ds)];
      else                 et = hold[0] & tx[0];
      if (sclk !== es) begin if (h / 2 < lead) l_bad++; else s_bad++; end
      if (frm !== ef) f_bad++;
      if (txd !== et) begin if (h / 2 < de) t_bad++; else e_bad++; end
      if (busy !== (h < 2 * tot - 1)) b_bad++;
      if (poke && h == 3) begin
        start = 1'b1; cfg_clk_mode = ~m[1:0]; cfg_frm_pol = ~pol[0];
        tx_word = ~tx; cfg_bits = 6'd3;
      end
      if (h[0] == 1'b0) rx_line = 1'b0;
      else              rx_line = pick(rx, bits, ds, (h + 1) / 2);
    end
    chk(s_bad == 0, {"R1 clock levels ", name}, s_bad, 0);
    chk(l_bad == 0, {"R2 idle clock in lead-in ", name}, l_bad, 0);
    chk(f_bad == 0, {"R3/R4 frame window ", name}, f_bad, 0);
    chk(t_bad == 0, {"R5 data order ", name}, t_bad, 0);
    chk(e_bad == 0, {"R6 end state in post-pad ", name}, e_bad, 0);
    chk(b_bad == 0, {"R10 transfer length ", name}, b_bad, 0);
    chk(done === 1'b1, {"R7 done at end ", name}, done, 1);
    chk(rx_word === (rx & mask), {"R7 received word ", name}, rx_word, rx & mask);
    @(posedge clk); #1;
    chk(done === 1'b0, {"R7 done single cycle ", name}, done, 0);
    chk(sclk === idle, {"R2 clock idle after ", name}, sclk, idle);
    chk(frm === !pol[0], {"R3 frame idle after ", name}, frm, !pol[0]);
    chk(txd === (hold[0] & tx[0]), {"R6 end state held ", name}, txd, hold[0] & tx[0]);
    repeat (3) @(posedge clk);
    #1 chk(busy === 1'b0, {"R9 no queued transfer ", name}, busy, 0);
  endtask

  // refused start
  task automatic run_bad(input int lead, input int pre, input int bits, input int post,
                         input int fdly, input int flen, input string name);
    cfg_lead = lead[2:0]; cfg_pre_pad = pre[1:0]; cfg_bits = bits[5:0];
    cfg_post_pad = post[1:0]; cfg_frm_dly = fdly[6:0]; cfg_frm_len = flen[5:0];
    start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    chk(err === 1'b1 && busy === 1'b0, {"R8 refused ", name}, {err, busy}, 2'b10);
    @(posedge clk); #1;
    chk(err === 1'b0 && busy === 1'b0, {"R8 err pulse ends ", name}, {err, busy}, 2'b00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(sclk === 1'b0 && frm === 1'b1 && txd === 1'b0, "R3 reset outputs",
        {sclk, frm, txd}, 3'b010);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R7 reset status",
        {busy, done, err}, 3'b000);
    run_xfer(0, 1, 2, 1, 8, 1, 4, 2, 0, 1, 32'h0000_00A5, 32'h0000_003C, 0, "mode0");
    run_xfer(1, 0, 0, 0, 4, 0, 0, 1, 1, 0, 32'h0000_0009, 32'h0000_0006, 0, "mode1 minimal");
    run_xfer(2, 1, 7, 3, 32, 3, 30, 10, 1, 0, 32'hC35A_0F71, 32'h8E21_B4D3, 0, "mode2 mid-data frame");
    run_xfer(3, 0, 1, 2, 12, 2, 3, 5, 0, 2, 32'h0000_0B6D, 32'h0000_0A53, 0, "mode3 div2");
    run_xfer(0, 1, 0, 0, 4, 0, 2, 3, 0, 0, 32'h0000_0006, 32'h0000_000B, 0, "frame ends at last half");
    run_xfer(0, 1, 2, 1, 8, 1, 4, 2, 1, 1, 32'h0000_00C3, 32'h0000_0071, 1, "R9 start while busy");
    run_bad(0, 0, 4, 0, 20, 3, "frame past end");
    run_bad(0, 0, 3, 0, 0, 1, "too few bits");
    run_bad(3, 0, 4, 0, 0, 2, "frame ends inside lead-in");
    run_bad(0, 0, 4, 0, 0, 4, "frame too long");
    run_bad(0, 0, 4, 0, 0, 0, "zero length");
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule